// File: doc/BRIEF.md
# DMA Status Register with Selectable Clear Mode

This block holds the status word that a DMA channel exposes to software. Four sticky event flags (error, abort, done and a blocked-transfer flag) are set by single-cycle pulses from the DMA engine. They stay set until software clears them. A separate control register carries one mode bit that picks, at run time, how software clears the flags. With the mode bit at 0, any read of the status word returns the flags and then clears them. With the mode bit at 1, a read leaves the flags alone, and software clears each flag by writing a 1 to its position. The status word also carries a live copy of the storage controller's interrupt line, which is never stored, plus three plain read/write bits.

Access goes over a single-cycle register port. A cycle with `bus_wr` high writes `bus_wdata` to the register at `bus_addr`. A cycle with `bus_rd` high loads `bus_rdata` at the next clock edge, and `bus_rdata` holds that value until the next read. Reads and writes complete in one cycle each, so the port has no back-pressure and no ready signal.

Top module: `dma_stat_clr`

## Requirements
- R1: After reset, all event flags and plain bits are 0 and the mode bit is 0. Reads of the status word (address 0x14) and of the control register (address 0x08) therefore return 0.
- R2: A one-cycle pulse on `ev_err`, `ev_abort`, `ev_done` or `ev_blk` sets status bit 1, 2, 3 or 6 respectively. The bit stays set until one of the clear mechanisms removes it.
- R3: When `bus_rd` is high with the status address, the status value appears on `bus_rdata` in the following cycle. Bit 4 of that value equals `scsi_irq` in the read cycle. Bit 4 has no storage.
- R4: With the mode bit at 0, a status read returns the flags as they were before the read and clears bits 1, 2, 3 and 6.
- R5: With the mode bit at 1, a status read leaves bits 1, 2, 3 and 6 unchanged.
- R6: With the mode bit at 1, a status write clears each of bits 1, 2, 3 and 6 for which the written bit is 1, and leaves the others unchanged. For example, writing 0x02 clears only bit 1.
- R7: With the mode bit at 0, a status write has no effect on bits 1, 2, 3 and 6.
- R8: An event pulse in the same cycle as a clearing read or write wins, and its bit is 1 afterwards.
- R9: Status bits 0, 5 and 7 are plain storage written by any status write in either mode. A write to bit 4 is ignored.
- R10: Bit 24 of the control register is the mode bit, written by any write to the control address. Control reads return the mode bit at bit 24 and 0 elsewhere. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| ev_err | input | 1 | Error event pulse |
| ev_abort | input | 1 | Abort event pulse |
| ev_done | input | 1 | Done event pulse |
| ev_blk | input | 1 | Blocked-transfer event pulse |
| scsi_irq | input | 1 | Live interrupt level from the storage controller |

## Verification
A clearing access can land in the same cycle as an event pulse that sets the same flag. This covers a clear-on-read in mode 0 and a write-one-to-clear in mode 1. The bench provokes this by driving the event pulse and the register access in the same cycle. It checks two things: the read issued in that cycle returns the value before the clear, and the next read shows the flag still set. A follow-up clear with no pulse confirms the flag then drops.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int STAT_W   = 8;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int BIT_ERR  = 1;
  localparam int BIT_ABT  = 2;
  localparam int BIT_DONE = 3;
  localparam int BIT_IRQ  = 4;
  localparam int BIT_BLK  = 6;
  localparam int MODE_BIT = 24;
  localparam logic [STAT_W-1:0] EV_MASK =
    STAT_W'((1 << BIT_ERR) | (1 << BIT_ABT) | (1 << BIT_DONE) | (1 << BIT_BLK));
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h08;
endpackage

// File: rtl/dsr_sticky_bit.sv
module dsr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R8: a pulse always leaves the flag set, whatever clear is active
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R2: without a clear, a set flag holds
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
endmodule

// File: rtl/dsr_ctrl_reg.sv
module dsr_ctrl_reg #(
  parameter int BUS_W    = 32,
  parameter int MODE_BIT = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [BUS_W-1:0] wdata,
  output logic             mode
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mode <= 1'b0;
    else if (wr_hit) mode <= wdata[MODE_BIT];
  end

  // R10: the mode bit moves only on a control write
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(mode));
endmodule

// File: rtl/dsr_status_bank.sv
module dsr_status_bank #(
  parameter int                 STAT_W  = 8,
  parameter logic [STAT_W-1:0]  EV_MASK = 8'h4E,
  parameter int                 BIT_IRQ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_vec,
  input  logic              rd_hit,
  input  logic              wr_hit,
  input  logic [STAT_W-1:0] wdata,
  input  logic              mode,
  input  logic              irq_live,
  output logic [STAT_W-1:0] view
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (EV_MASK[i]) begin : g_ev
      logic clr;
      assign clr = (rd_hit & ~mode) | (wr_hit & mode & wdata[i]);
      dsr_sticky_bit u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ev_vec[i]),
        .clr  (clr),
        .q    (view[i])
      );

      // R4: clear-on-read in mode 0
      a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !mode && !ev_vec[i]) |=> !view[i]);
      // R5: reads preserve in mode 1 unless a write clears
      a_r5_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && mode && !wr_hit && view[i]) |=> view[i]);
      // R6: write-one clears in mode 1
      a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && mode && wdata[i] && !ev_vec[i]) |=> !view[i]);
      // R7: writes do not touch flags in mode 0
      a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !mode && !rd_hit && !ev_vec[i]) |=> $stable(view[i]));
    end else if (i == BIT_IRQ) begin : g_irq
      assign view[i] = irq_live;
    end else begin : g_plain
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (wr_hit) q <= wdata[i];
      end
      assign view[i] = q;
    end
  end
endmodule

// File: rtl/dma_stat_clr.sv
module dma_stat_clr
  import dsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ev_err,
  input  logic              ev_abort,
  input  logic              ev_done,
  input  logic              ev_blk,
  input  logic              scsi_irq
);
  logic              stat_sel, ctrl_sel;
  logic              mode;
  logic [STAT_W-1:0] ev_vec;
  logic [STAT_W-1:0] stat_view;
  logic [BUS_W-1:0]  rd_next;

  assign stat_sel = (bus_addr == ADDR_STAT);
  assign ctrl_sel = (bus_addr == ADDR_CTRL);

  always_comb begin
    ev_vec           = '0;
    ev_vec[BIT_ERR]  = ev_err;
    ev_vec[BIT_ABT]  = ev_abort;
    ev_vec[BIT_DONE] = ev_done;
    ev_vec[BIT_BLK]  = ev_blk;
  end

  dsr_ctrl_reg #(.BUS_W(BUS_W), .MODE_BIT(MODE_BIT)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_hit(bus_wr & ctrl_sel),
    .wdata (bus_wdata),
    .mode  (mode)
  );

  dsr_status_bank #(.STAT_W(STAT_W), .EV_MASK(EV_MASK), .BIT_IRQ(BIT_IRQ)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_vec  (ev_vec),
    .rd_hit  (bus_rd & stat_sel),
    .wr_hit  (bus_wr & stat_sel),
    .wdata   (bus_wdata[STAT_W-1:0]),
    .mode    (mode),
    .irq_live(scsi_irq),
    .view    (stat_view)
  );

  always_comb begin
    rd_next = '0;
    if (stat_sel)      rd_next[STAT_W-1:0] = stat_view;
    else if (ctrl_sel) rd_next[MODE_BIT]   = mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R3: interrupt bit reflects the input during the read cycle
  a_r3_live_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && stat_sel) |=> (bus_rdata[BIT_IRQ] == $past(scsi_irq)));
  // R10: control read shows only the mode bit
  a_r10_ctrl_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ctrl_sel) |=> ($countones(bus_rdata) <= 1));
endmodule

// File: tb/tb_dma_stat_clr.sv
module tb_dma_stat_clr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        ev_err = 1'b0, ev_abort = 1'b0, ev_done = 1'b0, ev_blk = 1'b0;
  logic        scsi_irq = 1'b0;

  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_NONE = 8'h30;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  bit pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dma_stat_clr dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ev_err(ev_err), .ev_abort(ev_abort), .ev_done(ev_done), .ev_blk(ev_blk),
    .scsi_irq(scsi_irq)
  );

  // monitor: compares the read issued one cycle earlier
  always @(negedge clk) begin
    if (pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
    pend = bus_rd;
  end

  task automatic op(input bit w, input bit r, input logic [7:0] a,
                    input logic [31:0] wd, input logic [3:0] ev,
                    input logic [31:0] e, input string t);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = wd;
    {ev_blk, ev_done, ev_abort, ev_err} = ev;
    if (r) begin exp_q.push_back(e); tag_q.push_back(t); end
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_rd = 1'b0;
    {ev_blk, ev_done, ev_abort, ev_done} = 4'b0;
    ev_err = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    op(1'b0, 1'b1, a, 32'h0, 4'b0, e, t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    op(1'b1, 1'b0, a, d, 4'b0, 32'h0, "");
  endtask

  task automatic pulse(input logic [3:0] ev);
    op(1'b0, 1'b0, A_NONE, 32'h0, ev, 32'h0, "");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd(A_STAT, 32'h0, "R1 status after reset");
    rd(A_CTRL, 32'h0, "R1 control after reset");
    // R2 / R4 error flag, clear on read
    pulse(4'b0001);
    rd(A_STAT, 32'h02, "R2 error flag set");
    rd(A_STAT, 32'h00, "R4 cleared by read");
    // R2 / R3 other flags plus live interrupt
    pulse(4'b1110);
    scsi_irq = 1'b1;
    rd(A_STAT, 32'h5C, "R3 flags plus live irq");
    scsi_irq = 1'b0;
    rd(A_STAT, 32'h00, "R3 irq not stored, R4 cleared");
    // R7 / R9 mode 0 writes
    pulse(4'b0001);
    wr(A_STAT, 32'hFF);
    rd(A_STAT, 32'hA3, "R7 flag kept, R9 plain bits written");
    rd(A_STAT, 32'hA1, "R9 plain bits survive read");
    // R10 mode to 1
    wr(A_CTRL, 32'h0100_0000);
    rd(A_CTRL, 32'h0100_0000, "R10 mode bit readback");
    // R5 / R6 mode 1
    pulse(4'b1111);
    rd(A_STAT, 32'hEF, "R5 read preserves");
    rd(A_STAT, 32'hEF, "R5 second read preserves");
    wr(A_STAT, 32'hA3);
    rd(A_STAT, 32'hED, "R6 write 1 clears only bit 1");
    wr(A_STAT, 32'hA1);
    rd(A_STAT, 32'hED, "R6 zeros have no effect");
    wr(A_STAT, 32'hE9);
    rd(A_STAT, 32'hA5, "R6 clears bits 3 and 6");
    // R8 mode 1 collision
    op(1'b1, 1'b0, A_STAT, 32'hA5, 4'b0010, 32'h0, "");
    rd(A_STAT, 32'hA5, "R8 abort pulse beats w1c");
    wr(A_STAT, 32'hA5);
    rd(A_STAT, 32'hA1, "R6 clear after collision");
    // back to mode 0; R8 with clear-on-read
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, 32'h0, "R10 mode cleared");
    op(1'b0, 1'b1, A_STAT, 32'h0, 4'b0100, 32'hA1, "R8 read returns pre-pulse value");
    rd(A_STAT, 32'hA9, "R8 done pulse beats clear-on-read");
    rd(A_STAT, 32'hA1, "R4 clear after collision");
    // R10 other addresses / bits, R9 bit 4
    rd(A_NONE, 32'h0, "R10 unmapped read");
    wr(A_CTRL, 32'hFEFF_FFFF);
    rd(A_CTRL, 32'h0, "R10 other control bits ignored");
    wr(A_STAT, 32'h10);
    rd(A_STAT, 32'h00, "R9 bit 4 write ignored");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule